// File: doc/BRIEF.md
# Clock Mode Controller with Fixed-Clock Source Select

This block is the control side of an on-chip clock generator. Software writes a requested mode into a two-bit field, and the block reports the mode the generator is really in on a separate status field. The status follows the request only after a short settling delay, and only once the flags that the requested mode depends on (external reference ready, DCO ready) are asserted. If clock loss is flagged while the external reference is still good, a request for the external-with-loop mode is reported as the external-bypass mode.

Three further outputs are derived from the status mode and the loop settings. The first is the source of the fixed-frequency peripheral clock: off, the bus clock, or the external reference halved. The second is a flag that asks for the output divide to be doubled while the frequency loop is locking or relocking. The third is the length of the frequency-comparison window, which depends on the range bit. The oscillator, the DCO and the clock multiplexers are outside this block.

Top module: `clkmode_ctrl`

## Requirements
- R1: While reset is held and just after it is released, the status mode is 2'b00, the fixed-clock select is 2'b00 (off) and the loop is marked as locking for the first time.
- R2: Mode codes: 2'b00 self-clocked, 2'b01 internal reference with loop, 2'b10 external reference with loop bypassed, 2'b11 external reference with loop. The status takes the target mode on the 4th rising clock edge after the target and its entry conditions both become steady. It does not change earlier.
- R3: If the request changes before the status has updated, the count starts again from the new request.
- R4: Status 2'b10 is entered only while the external-ready input is 1. Until then the previous status holds.
- R5: Status 2'b11 is entered only while external-ready and DCO-ready are both 1.
- R6: With request 2'b11, loss-of-clock at 1 and external-ready at 1, the target is 2'b10 and the status settles to 2'b10.
- R7: Fixed-clock select codes are 2'b00 off, 2'b01 bus clock and 2'b10 external reference divided by two. In status 2'b00 or 2'b01 the select is 2'b00. In status 2'b10 it is 2'b01.
- R8: In status 2'b11 the select is 2'b10 exactly when lock is 1 and P×N ≥ 4×R. Otherwise it is 2'b01. P is 64 for range 0 and 1 for range 1, N = 2×mult+4, and R = 2^div.
- R9: The double-divide flag is 1 only in status 2'b11 while a lock is pending. A lock is pending after reset, and from the edge after any change of the multiplier field. It is cleared on the edge after lock goes from 0 to 1, and a multiplier change in the same cycle takes priority.
- R10: The comparison window is 2 reference cycles when range is 0 and 128 when range is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_mode | input | 2 | Requested clock mode |
| ext_ready | input | 1 | External reference is running and stable |
| dco_ready | input | 1 | DCO output is within range |
| lock | input | 1 | Frequency loop lock flag |
| loss_clk | input | 1 | Loss-of-clock flag |
| range_sel | input | 1 | Reference range: 0 low, 1 high |
| mult_fld | input | 3 | Loop multiplier field |
| div_fld | input | 3 | Output divider field |
| stat_mode | output | 2 | Actual clock mode |
| fix_sel | output | 2 | Fixed-clock source select |
| div_twice | output | 1 | Apply a 2R output divide instead of R |
| cmp_window | output | 8 | Comparison window length in reference cycles |

## Verification
The assertions assume that the flag inputs are synchronous to the bus clock and change at most once per cycle. They also assume that lock only has meaning once it has been observed low and then rising. The bench drives every input on the falling edge and changes one condition at a time, so each settling count has a clear start edge. The ratio sweep is run with the status held at 2'b11 and the mode inputs frozen, so the only values that change are range, multiplier, divider and lock.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
   typedef enum logic [1:0] {
      MD_SELF     = 2'b00,
      MD_INT_LOOP = 2'b01,
      MD_EXT_BYP  = 2'b10,
      MD_EXT_LOOP = 2'b11
   } md_e;

   typedef enum logic [1:0] {
      FX_OFF      = 2'b00,
      FX_BUS      = 2'b01,
      FX_EXT_HALF = 2'b10
   } fx_e;
endpackage

// File: rtl/mode_tracker.sv
module mode_tracker
   import clkmode_pkg::*;
#(
   parameter int SETTLE_CYCLES = 4,
   localparam int CNT_W = $clog2(SETTLE_CYCLES + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] req_mode,
   input  logic       ext_ready,
   input  logic       dco_ready,
   input  logic       loss_clk,
   output logic [1:0] stat_mode
);
   if (SETTLE_CYCLES < 2) begin : g_bad_settle
      $error("SETTLE_CYCLES must be at least 2");
   end

   md_e             target, tgt_q, stat_q;
   logic [3:0]      cond_vec;
   logic            cond_ok;
   logic [CNT_W-1:0] cnt;

   // Per-mode entry conditions
   for (genvar m = 0; m < 4; m++) begin : g_cond
      if (m == 3) begin : g_loop
         assign cond_vec[m] = ext_ready & dco_ready;
      end else if (m == 2) begin : g_byp
         assign cond_vec[m] = ext_ready;
      end else begin : g_free
         assign cond_vec[m] = 1'b1;
      end
   end

   always_comb begin
      if (md_e'(req_mode) == MD_EXT_LOOP && loss_clk && ext_ready)
         target = MD_EXT_BYP;
      else
         target = md_e'(req_mode);
      cond_ok = cond_vec[target];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= MD_SELF;
         tgt_q  <= MD_SELF;
         cnt    <= '0;
      end else begin
         tgt_q <= target;
         if (target != stat_q && cond_ok) begin
            if (target != tgt_q) begin
               cnt <= CNT_W'(1);
            end else if (cnt == CNT_W'(SETTLE_CYCLES - 1)) begin
               stat_q <= target;
               cnt    <= '0;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end else begin
            cnt <= '0;
         end
      end
   end

   assign stat_mode = stat_q;

   a_r2_no_jump_on_request: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(req_mode) |=> $stable(stat_mode));
   a_r4_bypass_needs_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(stat_mode) && stat_mode == MD_EXT_BYP) |-> $past(ext_ready));
   a_r5_loop_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(stat_mode) && stat_mode == MD_EXT_LOOP) |-> $past(ext_ready && dco_ready));
endmodule

// File: rtl/fixclk_select.sv
module fixclk_select
   import clkmode_pkg::*;
#(
   parameter int FLD_W = 3,
   parameter int P_LO  = 64,
   parameter int P_HI  = 1,
   localparam int CMP_W = (1 << FLD_W) + $clog2(P_LO + 1) + 4
) (
   input  logic [1:0]       mode,
   input  logic             range_sel,
   input  logic             lock,
   input  logic [FLD_W-1:0] mult_fld,
   input  logic [FLD_W-1:0] div_fld,
   output logic [1:0]       fix_sel
);
   if (P_HI < 1 || P_LO < P_HI) begin : g_bad_p
      $error("prescale factors must satisfy P_LO >= P_HI >= 1");
   end

   logic [CMP_W-1:0] p_val, n_val, r4_val, prod;
   logic             ratio_ok;

   always_comb begin
      p_val    = range_sel ? CMP_W'(P_HI) : CMP_W'(P_LO);
      n_val    = (CMP_W'(mult_fld) << 1) + CMP_W'(4);
      r4_val   = CMP_W'(4) << div_fld;
      prod     = p_val * n_val;
      ratio_ok = prod >= r4_val;
      case (md_e'(mode))
         MD_EXT_BYP:  fix_sel = FX_BUS;
         MD_EXT_LOOP: fix_sel = (ratio_ok && lock) ? FX_EXT_HALF : FX_BUS;
         default:     fix_sel = FX_OFF;
      endcase
   end
endmodule

// File: rtl/div_window.sv
module div_window
   import clkmode_pkg::*;
#(
   parameter int FLD_W  = 3,
   parameter int WIN_LO = 2,
   parameter int WIN_HI = 128,
   localparam int WIN_W = $clog2(WIN_HI + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             lock,
   input  logic             range_sel,
   input  logic [FLD_W-1:0] mult_fld,
   output logic             div_twice,
   output logic [WIN_W-1:0] cmp_window
);
   if (WIN_LO < 1 || WIN_HI < WIN_LO) begin : g_bad_win
      $error("window lengths must satisfy WIN_HI >= WIN_LO >= 1");
   end

   logic [FLD_W-1:0] mult_q;
   logic             lock_q, pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mult_q  <= '0;
         lock_q  <= 1'b0;
         pending <= 1'b1;
      end else begin
         mult_q <= mult_fld;
         lock_q <= lock;
         if (mult_fld != mult_q)
            pending <= 1'b1;
         else if (lock && !lock_q)
            pending <= 1'b0;
      end
   end

   assign div_twice = pending && md_e'(mode) == MD_EXT_LOOP;

   if (WIN_LO == WIN_HI) begin : g_win_fixed
      assign cmp_window = WIN_W'(WIN_HI);
   end else begin : g_win_mux
      assign cmp_window = range_sel ? WIN_W'(WIN_HI) : WIN_W'(WIN_LO);
   end

   a_r9_mult_change_relocks: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mult_fld) |=> pending);
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
   import clkmode_pkg::*;
#(
   parameter int SETTLE_CYCLES = 4,
   parameter int FLD_W         = 3,
   parameter int P_LO          = 64,
   parameter int P_HI          = 1,
   parameter int WIN_LO        = 2,
   parameter int WIN_HI        = 128,
   localparam int WIN_W        = $clog2(WIN_HI + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       req_mode,
   input  logic             ext_ready,
   input  logic             dco_ready,
   input  logic             lock,
   input  logic             loss_clk,
   input  logic             range_sel,
   input  logic [FLD_W-1:0] mult_fld,
   input  logic [FLD_W-1:0] div_fld,
   output logic [1:0]       stat_mode,
   output logic [1:0]       fix_sel,
   output logic             div_twice,
   output logic [WIN_W-1:0] cmp_window
);
   mode_tracker #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_track (
      .clk(clk), .rst_n(rst_n), .req_mode(req_mode), .ext_ready(ext_ready),
      .dco_ready(dco_ready), .loss_clk(loss_clk), .stat_mode(stat_mode)
   );

   fixclk_select #(.FLD_W(FLD_W), .P_LO(P_LO), .P_HI(P_HI)) u_fix (
      .mode(stat_mode), .range_sel(range_sel), .lock(lock),
      .mult_fld(mult_fld), .div_fld(div_fld), .fix_sel(fix_sel)
   );

   div_window #(.FLD_W(FLD_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_div (
      .clk(clk), .rst_n(rst_n), .mode(stat_mode), .lock(lock),
      .range_sel(range_sel), .mult_fld(mult_fld),
      .div_twice(div_twice), .cmp_window(cmp_window)
   );

   a_r8_half_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      fix_sel == FX_EXT_HALF |-> (lock && stat_mode == MD_EXT_LOOP));
   a_r7_off_in_internal: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_mode == MD_SELF || stat_mode == MD_INT_LOOP) |-> fix_sel == FX_OFF);
   a_r9_double_only_in_loop: assert property (@(posedge clk) disable iff (!rst_n)
      div_twice |-> stat_mode == MD_EXT_LOOP);
endmodule

// File: tb/sim_clkmode_ctrl.sv
module sim_clkmode_ctrl;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] req_mode;
   logic       ext_ready, dco_ready, lock, loss_clk, range_sel;
   logic [2:0] mult_fld, div_fld;
   logic [1:0] stat_mode, fix_sel;
   logic       div_twice;
   logic [7:0] cmp_window;
   int         checks = 0;
   int         errors = 0;

   always #5 clk = ~clk;

   clkmode_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req_mode(req_mode), .ext_ready(ext_ready),
      .dco_ready(dco_ready), .lock(lock), .loss_clk(loss_clk),
      .range_sel(range_sel), .mult_fld(mult_fld), .div_fld(div_fld),
      .stat_mode(stat_mode), .fix_sel(fix_sel), .div_twice(div_twice),
      .cmp_window(cmp_window)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_mode = 2'b00; ext_ready = 1'b0; dco_ready = 1'b0;
      lock = 1'b0; loss_clk = 1'b0; range_sel = 1'b0; mult_fld = 3'd0; div_fld = 3'd0;
      tick(3);
      chk("R1 status in reset", stat_mode, 0);
      rst_n = 1'b1;
      tick(1);
      chk("R1 status after reset", stat_mode, 0);
      chk("R1 fixed select off", fix_sel, 0);
      chk("R10 window range0", cmp_window, 2);
      range_sel = 1'b1; #1;
      chk("R10 window range1", cmp_window, 128);
      range_sel = 1'b0;

      // R2: settle timing toward internal loop mode
      req_mode = 2'b01;
      tick(3); chk("R2 before settle", stat_mode, 0);
      tick(1); chk("R2 after settle", stat_mode, 1);
      chk("R7 off in 01", fix_sel, 0);

      // R4: bypass waits for external ready
      req_mode = 2'b10;
      tick(8); chk("R4 held without ext", stat_mode, 1);
      ext_ready = 1'b1;
      tick(3); chk("R4 before settle", stat_mode, 1);
      tick(1); chk("R4 entered bypass", stat_mode, 2);
      chk("R7 bus in 10", fix_sel, 1);
      chk("R9 no double in 10", div_twice, 0);

      // R5: loop mode needs dco ready too
      req_mode = 2'b11;
      tick(6); chk("R5 held without dco", stat_mode, 2);
      dco_ready = 1'b1;
      tick(2);
      req_mode = 2'b00;       // R3 restart
      tick(2); chk("R3 no early switch", stat_mode, 2);
      req_mode = 2'b11;
      tick(3); chk("R3 count restarted", stat_mode, 2);
      tick(1); chk("R5 entered loop", stat_mode, 3);

      // R8/R9 in loop mode, lock low
      chk("R8 bus while unlocked", fix_sel, 1);
      chk("R9 initial lock pending", div_twice, 1);
      lock = 1'b1;
      tick(1); chk("R9 cleared on lock rise", div_twice, 0);
      chk("R8 half at 64x4 vs 4", fix_sel, 2);

      // R8 sweep over range, mult, div and lock
      for (int lk = 0; lk < 2; lk++)
         for (int rg = 0; rg < 2; rg++)
            for (int m = 0; m < 8; m++)
               for (int d = 0; d < 8; d++) begin
                  int p, exp_sel;
                  lock = lk[0]; range_sel = rg[0]; mult_fld = m[2:0]; div_fld = d[2:0];
                  #1;
                  p = (rg == 1) ? 1 : 64;
                  exp_sel = (lk == 1 && p * (2 * m + 4) >= 4 * (1 << d)) ? 2 : 1;
                  chk($sformatf("R8 sweep lk%0d rg%0d m%0d d%0d", lk, rg, m, d), fix_sel, exp_sel);
               end
      tick(1);

      // R9 relock after multiplier change
      lock = 1'b0; tick(1);
      lock = 1'b1; tick(1);
      chk("R9 clear after relock", div_twice, 0);
      mult_fld = 3'd3;
      tick(1); chk("R9 set on mult change", div_twice, 1);
      tick(3); chk("R9 held until lock rise", div_twice, 1);
      lock = 1'b0; tick(1);
      lock = 1'b1; tick(1);
      chk("R9 cleared after regain", div_twice, 0);

      // R6 loss of clock
      loss_clk = 1'b1;
      tick(3); chk("R6 before settle", stat_mode, 3);
      tick(1); chk("R6 reports bypass", stat_mode, 2);
      chk("R7 bus after loss", fix_sel, 1);
      loss_clk = 1'b0;
      tick(4); chk("R6 back to loop", stat_mode, 3);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule